// File: doc/BRIEF.md
# LSB-First SPI Register Engine with CRC-8

This block is the serial front end of a register-mapped peripheral. A host drives chip select, serial clock and data in SPI mode 0. The block samples each input bit on a rising clock edge and changes its output bit on a falling edge. Both directions run least significant bit first. Every frame opens with an 8-bit header: a 6-bit register address, a direction bit and a burst bit. A 16-bit payload follows. An optional CRC-8 trailer may close the frame. The block turns each complete frame into one write or into one or more read strobes on a synchronous register port. These strobes fire after chip select returns high.

All pins are brought into the system clock domain through two-flop synchronisers. The system clock must run at least eight times faster than SCLK. The register file must return `reg_rdata` combinationally for the current `reg_addr`, with no side effects. The block uses that path to fetch each outgoing word just before it is shifted out. Side effects of a read, such as clearing a status word, belong on the `reg_rd` strobe. That strobe fires once per returned word, after the frame has been accepted.

A burst read of the raw-data base address or the filtered-data base address returns the four channel words and then the status word in one frame. The engine sizes each frame from the header and from the CRC setting. Over-length frames still execute. Short frames and CRC mismatches are dropped, and each kind raises its own one-cycle error pulse.

Top module: `spi_lsb_engine`

## Requirements
- R1: After reset `sdo_oe`, `reg_wr`, `reg_rd`, `frm_err` and `crc_err` are all low.
- R2: Header bit 0..5 is the address (LSB first), bit 6 is direction (1 = write), bit 7 is burst, bits 8..23 are the payload LSB first. A write frame produces exactly one `reg_wr` pulse, carrying that address and payload, and only after CS rises.
- R3: In a single read, SDO bits 0..7 are 0 and bits 8..23 carry the word at the header address LSB first. One `reg_rd` strobe follows CS rising, at that address.
- R4: A read with burst bit 1 at address 0x01 is 88 bits long (without CRC). SDO carries the words of 0x01, 0x02, 0x03, 0x04 and then the status address 0x12, in that order. Five `reg_rd` strobes follow, in the same address order.
- R5: A burst read at address 0x05 returns 0x05..0x08 and then 0x12, with five strobes in that order.
- R6: The burst bit has no effect for any other read address or for writes. Such frames need only 24 bits and give one strobe.
- R7: A frame shorter than its expected length (24/32 single, 88/96 burst) raises `frm_err` for one cycle and issues no write and no read strobe.
- R8: A frame longer than expected still executes, using the first bits received.
- R9: With CRC on, the last 8 bits of the expected length are a CRC (polynomial x^8+x^2+x+1, initial 0) over all earlier SDI bits in wire order, sent remainder MSB first. A mismatch raises `crc_err` for one cycle and discards the frame, reads included.
- R10: With CRC on, a 24-bit single frame is a framing error only; `crc_err` stays low.
- R11: With CRC on, the 8 SDO bits after the data carry the same CRC computed over all earlier SDO bits, MSB first.
- R12: While CS is high, `sdo_oe` is low and SCLK/SDI activity has no effect on later frames or on the register port.
- R13: `crc_en` is sampled when CS falls; changing it mid-frame does not alter that frame's expected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | SDO drive enable, high only inside a frame |
| crc_en | input | 1 | CRC trailer enable from the control register |
| reg_addr | output | 6 | Register address for fetch, write and read strobe |
| reg_wdata | output | 16 | Write data |
| reg_wr | output | 1 | One-cycle write pulse |
| reg_rd | output | 1 | One-cycle strobe per returned word |
| reg_rdata | input | 16 | Combinational read data for `reg_addr` |
| frm_err | output | 1 | One-cycle framing error pulse |
| crc_err | output | 1 | One-cycle CRC error pulse |

## Verification
At the rising edge of CS the length check and the CRC check are judged in the same cycle. A frame can fail both at once. The bench provokes this case by enabling CRC and sending a bare 24-bit frame whose CRC slot never arrives. It then requires exactly one framing pulse, no CRC pulse and no register access. A second case sends a long enough frame with a flipped CRC bit, and this must give the CRC pulse alone. In every frame the bench also checks that nothing reaches the register port before CS rises.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

    localparam int          CRC_W    = 8;
    localparam logic [7:0]  CRC_POLY = 8'h07;

    // Reverse bit order so that the remainder leaves MSB first from an LSB-first shifter.
    function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= din[i];
                sync_q <= meta_q;
            end
        end
        assign dout[i] = sync_q;
    end
endmodule

// File: rtl/spi_crc_step.sv
`timescale 1ns/1ps
module spi_crc_step #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb    = crc_i[W-1] ^ bit_i;
    assign crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/spi_lsb_engine.sv
`timescale 1ns/1ps
module spi_lsb_engine
    import spi_eng_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                DATA_W      = 16,
    parameter int                N_CH        = 4,
    parameter logic [ADDR_W-1:0] RAW_BASE    = 6'h01,
    parameter logic [ADDR_W-1:0] FILT_BASE   = 6'h05,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              crc_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              frm_err,
    output logic              crc_err
);
    localparam int HDR_W      = ADDR_W + 2;
    localparam int SINGLE_LEN = HDR_W + DATA_W;
    localparam int BURST_LEN  = HDR_W + (N_CH + 1) * DATA_W;
    localparam int MAX_LEN    = BURST_LEN + CRC_W;
    localparam int CNT_W      = $clog2(MAX_LEN + 1) + 1;
    localparam int IDX_W      = $clog2(N_CH + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              sclk_p;
        logic              csn_p;
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              burst;
        logic [DATA_W-1:0] pay;
        logic              crc_on;
        logic              crc_ok;
        logic [CRC_W-1:0]  crc_rx;
        logic [CRC_W-1:0]  crc_tx;
        logic [DATA_W-1:0] tx;
        logic              sdo;
        logic              load;
        logic [IDX_W-1:0]  widx;
        logic              wr_p;
        logic              frm;
        logic              crcerr;
        logic              cm_act;
        logic [IDX_W-1:0]  cm_idx;
        logic [IDX_W-1:0]  cm_last;
        logic [ADDR_W-1:0] cm_base;
    } eng_st_t;

    eng_st_t st_q, st_d;

    logic s_sclk, s_csn, s_sdi;
    spi_pin_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sdi, cs_n, sclk}), .dout({s_sdi, s_csn, s_sclk})
    );

    logic [CRC_W-1:0] rx_crc_nx, tx_crc_nx;
    spi_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc_rx (
        .crc_i(st_q.crc_rx), .bit_i(s_sdi), .crc_o(rx_crc_nx)
    );
    spi_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc_tx (
        .crc_i(st_q.crc_tx), .bit_i(st_q.sdo), .crc_o(tx_crc_nx)
    );

    function automatic logic is_burst(input logic [ADDR_W-1:0] a, input logic w, input logic b);
        return b && !w && (a == RAW_BASE || a == FILT_BASE);
    endfunction

    function automatic logic [CNT_W-1:0] data_len(input logic [ADDR_W-1:0] a, input logic w,
                                                  input logic b);
        return is_burst(a, w, b) ? CNT_W'(BURST_LEN) : CNT_W'(SINGLE_LEN);
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(input logic [ADDR_W-1:0] a, input logic w,
                                                   input logic b, input logic c);
        return data_len(a, w, b) + (c ? CNT_W'(CRC_W) : '0);
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [IDX_W-1:0] idx);
        return (int'(idx) < N_CH) ? base + ADDR_W'(idx) : STATUS_ADDR;
    endfunction

    logic sclk_rise, sclk_fall, cs_fall, cs_rise;
    assign sclk_rise = s_sclk & ~st_q.sclk_p;
    assign sclk_fall = ~s_sclk & st_q.sclk_p;
    assign cs_fall   = ~s_csn & st_q.csn_p;
    assign cs_rise   = s_csn & ~st_q.csn_p;

    always_comb begin
        logic [CNT_W-1:0] c_v, nc_v, len_v, dend_v;
        st_d        = st_q;
        st_d.sclk_p = s_sclk;
        st_d.csn_p  = s_csn;
        st_d.wr_p   = 1'b0;
        st_d.frm    = 1'b0;
        st_d.crcerr = 1'b0;
        c_v    = st_q.cnt;
        nc_v   = (c_v == CNT_MAX) ? c_v : c_v + 1'b1;
        len_v  = '0;
        dend_v = '0;

        if (st_q.cm_act) begin
            st_d.cm_idx = st_q.cm_idx + 1'b1;
            if (st_q.cm_idx == st_q.cm_last) st_d.cm_act = 1'b0;
        end
        if (st_q.load) begin
            st_d.tx   = reg_rdata;
            st_d.widx = st_q.widx + 1'b1;
            st_d.load = 1'b0;
        end

        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.addr   = '0;
            st_d.wr     = 1'b0;
            st_d.burst  = 1'b0;
            st_d.pay    = '0;
            st_d.crc_on = crc_en;
            st_d.crc_ok = ~crc_en;
            st_d.crc_rx = '0;
            st_d.crc_tx = '0;
            st_d.tx     = '0;
            st_d.sdo    = 1'b0;
            st_d.load   = 1'b0;
            st_d.widx   = '0;
        end else if (cs_rise && st_q.active) begin
            st_d.active = 1'b0;
            len_v = frame_len(st_q.addr, st_q.wr, st_q.burst, st_q.crc_on);
            if (st_q.cnt < len_v) begin
                st_d.frm = 1'b1;
            end else if (!st_q.crc_ok) begin
                st_d.crcerr = 1'b1;
            end else if (st_q.wr) begin
                st_d.wr_p = 1'b1;
            end else begin
                st_d.cm_act  = 1'b1;
                st_d.cm_idx  = '0;
                st_d.cm_last = is_burst(st_q.addr, st_q.wr, st_q.burst) ? IDX_W'(N_CH) : '0;
                st_d.cm_base = st_q.addr;
            end
        end else if (st_q.active && sclk_rise) begin
            for (int i = 0; i < ADDR_W; i++)
                if (c_v == CNT_W'(i)) st_d.addr[i] = s_sdi;
            if (c_v == CNT_W'(ADDR_W))     st_d.wr    = s_sdi;
            if (c_v == CNT_W'(ADDR_W + 1)) st_d.burst = s_sdi;
            for (int i = 0; i < DATA_W; i++)
                if (c_v == CNT_W'(HDR_W + i)) st_d.pay[i] = s_sdi;
            len_v  = frame_len(st_d.addr, st_d.wr, st_d.burst, st_q.crc_on);
            dend_v = data_len(st_d.addr, st_d.wr, st_d.burst);
            if (c_v < len_v) st_d.crc_rx = rx_crc_nx;
            if (st_q.crc_on && nc_v == len_v) st_d.crc_ok = (rx_crc_nx == '0);
            if (c_v < dend_v) st_d.crc_tx = tx_crc_nx;
            st_d.cnt = nc_v;
            if (!st_d.wr && nc_v >= CNT_W'(HDR_W) && nc_v < dend_v &&
                ((nc_v - CNT_W'(HDR_W)) % CNT_W'(DATA_W)) == '0)
                st_d.load = 1'b1;
            if (st_q.crc_on && nc_v == dend_v)
                st_d.tx = DATA_W'(bit_rev(tx_crc_nx));
        end else if (st_q.active && sclk_fall) begin
            st_d.sdo = st_q.tx[0];
            st_d.tx  = st_q.tx >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.csn_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo       = st_q.sdo;
    assign sdo_oe    = st_q.active;
    assign reg_wr    = st_q.wr_p;
    assign reg_rd    = st_q.cm_act;
    assign reg_wdata = st_q.pay;
    assign frm_err   = st_q.frm;
    assign crc_err   = st_q.crcerr;
    assign reg_addr  = st_q.cm_act ? word_addr(st_q.cm_base, st_q.cm_idx)
                                   : word_addr(st_q.addr, st_q.widx);

    // Checker state: length of the current run of read strobes.
    logic [IDX_W:0] rd_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_run_q <= '0;
        else if (reg_rd) rd_run_q <= rd_run_q + 1'b1;
        else             rd_run_q <= '0;
    end

    // R7
    frm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |-> (!reg_wr && !reg_rd));
    // R9
    crc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> (!reg_wr && !reg_rd && !frm_err));
    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R12
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err || crc_err || reg_wr) |-> !sdo_oe);
    // R4
    rd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (rd_run_q < (IDX_W+1)'(N_CH + 1)));
endmodule

// File: tb/spi_lsb_engine_tb.sv
`timescale 1ns/1ps
module spi_lsb_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        crc_en = 1'b0;
    logic        sdo, sdo_oe, reg_wr, reg_rd, frm_err, crc_err;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_lsb_engine u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .crc_en(crc_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .frm_err(frm_err), .crc_err(crc_err)
    );

    function automatic logic [15:0] model_word(input logic [5:0] a);
        return 16'h3C00 ^ {a, a[3:0], a};
    endfunction
    assign reg_rdata = model_word(reg_addr);

    // Port monitor
    int          wr_cnt = 0, rd_cnt = 0, frm_cnt = 0, crc_cnt = 0;
    logic [5:0]  wr_addr_l = '0;
    logic [15:0] wr_data_l = '0;
    logic [5:0]  rd_log [64];
    always @(negedge clk) begin
        if (reg_wr) begin wr_cnt++; wr_addr_l = reg_addr; wr_data_l = reg_wdata; end
        if (reg_rd) begin rd_log[rd_cnt % 64] = reg_addr; rd_cnt++; end
        if (frm_err) frm_cnt++;
        if (crc_err) crc_cnt++;
    end

    int vec = 0, miss = 0;
    bit done = 1'b0;
    int pre_acc;
    int b_wr, b_rd, b_frm, b_crc;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mark();
        b_wr = wr_cnt; b_rd = rd_cnt; b_frm = frm_cnt; b_crc = crc_cnt;
    endtask

    function automatic logic [127:0] mkf(input logic [5:0] a, input bit w, input bit b,
                                         input logic [15:0] p);
        logic [127:0] f = '0;
        f[5:0] = a; f[6] = w; f[7] = b; f[23:8] = p;
        return f;
    endfunction

    function automatic logic [7:0] crc_of(input logic [127:0] f, input int n);
        logic [7:0] c = '0;
        for (int i = 0; i < n; i++) begin
            logic fb = c[7] ^ f[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [127:0] add_crc(input logic [127:0] f, input int n);
        logic [7:0] c = crc_of(f, n);
        for (int j = 0; j < 8; j++) f[n+j] = c[7-j];
        return f;
    endfunction

    function automatic logic [7:0] crc_field(input logic [127:0] f, input int n);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[7-j] = f[n+j];
        return r;
    endfunction

    task automatic xfer(input logic [127:0] mosi, input int n, output logic [127:0] miso,
                        input int flip_at = -1, input logic flip_val = 1'b0);
        miso = '0;
        mark();
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i == flip_at) crc_en = flip_val;
            sdi = mosi[i];
            #HALF;
            sclk = 1'b1;
            miso[i] = sdo;
            #HALF;
            sclk = 1'b0;
        end
        #HALF;
        pre_acc = (wr_cnt - b_wr) + (rd_cnt - b_rd) + (frm_cnt - b_frm) + (crc_cnt - b_crc);
        cs_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sdo_oe", 32'(sdo_oe), 0);
        chk("R1 strobes", {28'd0, reg_wr, reg_rd, frm_err, crc_err}, 0);
    endtask

    task automatic t_write();
        logic [127:0] so;
        xfer(mkf(6'h14, 1, 0, 16'hBEEF), 24, so);
        chk("R2 nothing before CS rise", pre_acc, 0);
        chk("R2 write count", wr_cnt - b_wr, 1);
        chk("R2 write addr", 32'(wr_addr_l), 32'h14);
        chk("R2 write data", 32'(wr_data_l), 32'hBEEF);
    endtask

    task automatic t_single_read();
        logic [127:0] so;
        xfer(mkf(6'h09, 0, 0, 16'h0), 24, so);
        chk("R3 header slot", 32'(so[7:0]), 0);
        chk("R3 data word", 32'(so[23:8]), 32'(model_word(6'h09)));
        chk("R3 strobe count", rd_cnt - b_rd, 1);
        chk("R3 strobe addr", 32'(rd_log[b_rd % 64]), 32'h09);
    endtask

    task automatic t_burst(input logic [5:0] base, input string req);
        logic [127:0] so;
        logic [5:0]   ea;
        xfer(mkf(base, 0, 1, 16'h0), 88, so);
        chk({req, " framing"}, frm_cnt - b_frm, 0);
        chk({req, " strobe count"}, rd_cnt - b_rd, 5);
        for (int k = 0; k < 5; k++) begin
            ea = (k < 4) ? base + 6'(k) : 6'h12;
            chk({req, " burst word"}, 32'(so[8+16*k +: 16]), 32'(model_word(ea)));
            chk({req, " strobe order"}, 32'(rd_log[(b_rd + k) % 64]), 32'(ea));
        end
    endtask

    task automatic t_ignore();
        logic [127:0] so;
        xfer(mkf(6'h0A, 0, 1, 16'h0), 24, so);
        chk("R6 read no framing err", frm_cnt - b_frm, 0);
        chk("R6 read single strobe", rd_cnt - b_rd, 1);
        chk("R6 read word", 32'(so[23:8]), 32'(model_word(6'h0A)));
        xfer(mkf(6'h01, 1, 1, 16'h1234), 24, so);
        chk("R6 write with burst bit", wr_cnt - b_wr, 1);
        chk("R6 write data", 32'(wr_data_l), 32'h1234);
        chk("R6 no read strobe", rd_cnt - b_rd, 0);
    endtask

    task automatic t_short();
        logic [127:0] so;
        xfer(mkf(6'h03, 1, 0, 16'hAAAA), 23, so);
        chk("R7 short write frm_err", frm_cnt - b_frm, 1);
        chk("R7 short write no write", wr_cnt - b_wr, 0);
        xfer(mkf(6'h05, 0, 1, 16'h0), 87, so);
        chk("R7 short burst frm_err", frm_cnt - b_frm, 1);
        chk("R7 short burst no strobe", rd_cnt - b_rd, 0);
    endtask

    task automatic t_long();
        logic [127:0] so;
        logic [127:0] f = mkf(6'h22, 1, 0, 16'h5A5A);
        f[39:24] = 16'hFFFF;
        xfer(f, 40, so);
        chk("R8 long write executes", wr_cnt - b_wr, 1);
        chk("R8 long write data", 32'(wr_data_l), 32'h5A5A);
        chk("R8 no framing err", frm_cnt - b_frm, 0);
    endtask

    task automatic t_crc();
        logic [127:0] so, f;
        @(negedge clk); crc_en = 1'b1;
        xfer(add_crc(mkf(6'h15, 1, 0, 16'hC0DE), 24), 32, so);
        chk("R9 good crc write", wr_cnt - b_wr, 1);
        chk("R9 good crc data", 32'(wr_data_l), 32'hC0DE);
        chk("R9 no crc err", crc_cnt - b_crc, 0);
        f = add_crc(mkf(6'h15, 1, 0, 16'h0F0F), 24);
        f[27] = ~f[27];
        xfer(f, 32, so);
        chk("R9 bad crc flagged", crc_cnt - b_crc, 1);
        chk("R9 bad crc discarded", wr_cnt - b_wr, 0);
        f = add_crc(mkf(6'h0B, 0, 0, 16'h0), 24);
        f[30] = ~f[30];
        xfer(f, 32, so);
        chk("R9 bad crc read no strobe", rd_cnt - b_rd, 0);
        xfer(mkf(6'h16, 1, 0, 16'h7777), 24, so);
        chk("R10 24-bit with crc frm_err", frm_cnt - b_frm, 1);
        chk("R10 no crc err", crc_cnt - b_crc, 0);
        chk("R10 no write", wr_cnt - b_wr, 0);
        xfer(add_crc(mkf(6'h0B, 0, 0, 16'h0), 24), 32, so);
        chk("R11 single read word", 32'(so[23:8]), 32'(model_word(6'h0B)));
        chk("R11 single read sdo crc", 32'(crc_field(so, 24)), 32'(crc_of(so, 24)));
        chk("R11 single read strobe", rd_cnt - b_rd, 1);
        xfer(add_crc(mkf(6'h05, 0, 1, 16'h0), 88), 96, so);
        chk("R11 burst strobes", rd_cnt - b_rd, 5);
        chk("R11 burst sdo crc", 32'(crc_field(so, 88)), 32'(crc_of(so, 88)));
        xfer(add_crc(mkf(6'h17, 1, 0, 16'h2468), 24), 32, so, 10, 1'b0);
        chk("R13 crc frame kept after drop", wr_cnt - b_wr, 1);
        chk("R13 data", 32'(wr_data_l), 32'h2468);
        xfer(mkf(6'h18, 1, 0, 16'h1357), 24, so, 10, 1'b1);
        chk("R13 plain frame kept after raise", wr_cnt - b_wr, 1);
        chk("R13 no framing err", frm_cnt - b_frm, 0);
        @(negedge clk); crc_en = 1'b0;
    endtask

    task automatic t_idle();
        logic [127:0] so;
        int oe_hits = 0;
        mark();
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            sdi = i[0] ^ i[2];
            #HALF; sclk = 1'b1;
            if (sdo_oe) oe_hits++;
            #HALF; sclk = 1'b0;
        end
        repeat (20) @(negedge clk);
        chk("R12 sdo_oe low while CS high", oe_hits, 0);
        chk("R12 no port activity", (wr_cnt - b_wr) + (rd_cnt - b_rd) + (frm_cnt - b_frm), 0);
        xfer(mkf(6'h21, 1, 0, 16'h8001), 24, so);
        chk("R12 next frame addr", 32'(wr_addr_l), 32'h21);
        chk("R12 next frame data", 32'(wr_data_l), 32'h8001);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_single_read();
        t_burst(6'h01, "R4");
        t_burst(6'h05, "R5");
        t_ignore();
        t_short();
        t_long();
        t_crc();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec + 1, miss + 1);
            $finish;
        end
    end
endmodule